// File: doc/BRIEF.md
# Descriptor Pointer Sequencer

This block keeps the two descriptor pointers of a single DMA channel: the pointer to the next descriptor and the pointer to the descriptor currently being fetched. When the transfer engine asks for a new descriptor, the block fetches its 16-bit elements one at a time over a plain read request/response port. The current pointer moves forward two bytes per element, and each element is handed out on a strobe-qualified output for the engine to consume. In the two linked-list modes the fetch is seeded from the next pointer, and the leading element or elements of the descriptor overwrite that next pointer as the link field. In array mode the next pointer plays no part, and descriptors are read back to back from wherever the current pointer stands.

Software programs the pointers through a small register port. Writes are accepted only while the channel is disabled and the sequencer is idle. Reads are allowed at any time. The sequencer has three states. IDLE waits for a start request. FETCH issues reads and collects responses. DONE lasts one cycle and flags the finished descriptor. The transitions are: IDLE to FETCH on start with the channel enabled; FETCH to DONE when the last element is accepted; DONE to IDLE unconditionally. Reset clears both pointers to zero, but software must not rely on that value.

Top module: `desc_ptr_seq`

## Requirements
- R1: During and directly after reset, `mem_req`, `elem_valid` and `desc_done` are low and the sequencer is in IDLE.
- R2: `reg_rdata` always returns the register chosen by `reg_sel` (0 = next pointer, 1 = current pointer). With `chan_en` low and the sequencer idle, a cycle with `reg_wr` high loads `reg_wdata` into that register.
- R3: While `chan_en` is high, register writes are dropped and neither pointer changes through the register port.
- R4: A start request is honoured only in IDLE with `chan_en` high. With `chan_en` low, `start_req` produces no read and leaves both pointers unchanged.
- R5: In list modes (`mode_sel` 2'b00 small, 2'b01 large), accepting a start copies the next pointer into the current pointer, so the first read address equals the next pointer.
- R6: At most one read is outstanding. `mem_req` is a one-cycle pulse and stays low until the response is accepted. A `mem_rvalid` that arrives with no read pending is ignored.
- R7: `mem_addr` equals the current pointer. Each accepted response adds 2 to the current pointer, wrapping modulo 2^32.
- R8: In the cycle a response is accepted, `elem_valid` is high, `elem_data` equals `mem_rdata` and `elem_idx` gives the element position within the descriptor, starting at 0.
- R9: Small list mode reads `N_SMALL` elements. Element 0 replaces bits 15:0 of the next pointer, and bits 31:16 are kept.
- R10: Large list mode reads `N_LARGE` elements. Element 0 replaces bits 15:0 of the next pointer and element 1 replaces bits 31:16.
- R11: Array mode (`mode_sel[1]` = 1) reads `N_ARRAY` elements from the current pointer without reloading it and leaves the next pointer unchanged.
- R12: `desc_done` is high for exactly the one cycle after the last element is accepted. The sequencer is then back in IDLE and can accept the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; locks the pointers when high |
| mode_sel | input | 2 | 00 small list, 01 large list, 1x array |
| start_req | input | 1 | Request to fetch the next descriptor |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 next pointer, 1 current pointer |
| reg_wdata | input | PTR_W | Register write data |
| reg_rdata | output | PTR_W | Selected register contents |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | PTR_W | Read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | ELEM_W | Read response data |
| elem_valid | output | 1 | Fetched element strobe |
| elem_data | output | ELEM_W | Fetched element |
| elem_idx | output | IDX_W | Position of the element in the descriptor |
| desc_done | output | 1 | Descriptor fully fetched |

## Verification
The hardest case to reach is a chain of descriptors in which the link field just fetched seeds the next fetch, with no register access in between. Reaching it also means the pointer has to wrap both at the 16-bit half boundary and at the top of the 32-bit space. The bench programs seed pointers near those boundaries and runs two descriptors back to back in each list mode. It builds the memory contents as a function of the address, so each new link is predictable. Response latency changes from element to element to test the single-outstanding rule, and a stray response is driven while the sequencer is idle.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;

    localparam logic [1:0] MODE_SMALL = 2'b00;
    localparam logic [1:0] MODE_LARGE = 2'b01;

    function automatic logic mode_is_array(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic mode_is_large(input logic [1:0] m);
        return (m == MODE_LARGE);
    endfunction

endpackage

// File: rtl/dps_fsm.sv
module dps_fsm
    import dps_pkg::*;
#(
    parameter int N_SMALL = 4,
    parameter int N_LARGE = 6,
    parameter int N_ARRAY = 4,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             start_req,
    input  logic [1:0]       mode_sel,
    input  logic             rsp_valid,
    output seq_state_e       state,
    output logic [1:0]       mode_q,
    output logic             seed_list,
    output logic             mem_req,
    output logic             rsp_accept,
    output logic [IDX_W-1:0] elem_idx,
    output logic             done_pulse
);

    localparam logic [IDX_W-1:0] LAST_SMALL = IDX_W'(N_SMALL - 1);
    localparam logic [IDX_W-1:0] LAST_LARGE = IDX_W'(N_LARGE - 1);
    localparam logic [IDX_W-1:0] LAST_ARRAY = IDX_W'(N_ARRAY - 1);

    seq_state_e       state_n;
    logic             waiting;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] last_idx;
    logic             start_ok;
    logic             last_elem;

    // Decode of the current cycle
    always_comb begin
        start_ok   = (state == ST_IDLE) && chan_en && start_req;
        seed_list  = start_ok && !mode_is_array(mode_sel);
        mem_req    = (state == ST_FETCH) && !waiting;
        rsp_accept = (state == ST_FETCH) && waiting && rsp_valid;
        elem_idx   = cnt;
        done_pulse = (state == ST_DONE);
        if (mode_is_array(mode_q))
            last_idx = LAST_ARRAY;
        else if (mode_is_large(mode_q))
            last_idx = LAST_LARGE;
        else
            last_idx = LAST_SMALL;
        last_elem  = rsp_accept && (cnt == last_idx);
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start_ok)  state_n = ST_FETCH;
            ST_FETCH: if (last_elem) state_n = ST_DONE;
            ST_DONE:                 state_n = ST_IDLE;
            default:                 state_n = ST_IDLE;
        endcase
    end

    // State register and fetch bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= MODE_SMALL;
            waiting <= 1'b0;
            cnt     <= '0;
        end else begin
            state <= state_n;
            if (start_ok) begin
                mode_q <= mode_sel;
                cnt    <= '0;
            end else if (rsp_accept) begin
                cnt <= cnt + 1'b1;
            end
            if (mem_req)
                waiting <= 1'b1;
            else if (rsp_accept)
                waiting <= 1'b0;
        end
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);                                              // R6
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));                         // R12
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !(chan_en && start_req)) |=> (state == ST_IDLE)); // R4
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH) |-> !mem_req);                                  // R1

endmodule

// File: rtl/dps_ptr_regs.sv
module dps_ptr_regs #(
    parameter int PTR_W      = 32,
    parameter int ELEM_W     = 16,
    parameter int IDX_W      = 3,
    parameter int LINK_SMALL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [PTR_W-1:0]  wr_data,
    input  logic              seed_list,
    input  logic              rsp_accept,
    input  logic [IDX_W-1:0]  elem_idx,
    input  logic [ELEM_W-1:0] elem_data,
    input  logic [1:0]        mode_q,
    input  logic              fetching,
    output logic [PTR_W-1:0]  next_ptr,
    output logic [PTR_W-1:0]  curr_ptr
);

    localparam int HALVES = PTR_W / ELEM_W;
    localparam logic [PTR_W-1:0] STEP = PTR_W'(ELEM_W / 8);

    logic [ELEM_W-1:0] nxt_h [HALVES];

    // Current pointer: software load, seed from next, or advance per element
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            curr_ptr <= '0;
        else if (wr_en && wr_sel)
            curr_ptr <= wr_data;
        else if (seed_list)
            curr_ptr <= next_ptr;
        else if (rsp_accept)
            curr_ptr <= curr_ptr + STEP;
    end

    // Next pointer, one slice per element width; slices take link elements
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic link_hit;
        assign link_hit = rsp_accept && !mode_q[1] &&
                          (elem_idx == IDX_W'(h)) &&
                          (mode_q[0] || (h < LINK_SMALL));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                nxt_h[h] <= '0;
            else if (wr_en && !wr_sel)
                nxt_h[h] <= wr_data[h*ELEM_W +: ELEM_W];
            else if (link_hit)
                nxt_h[h] <= elem_data;
        end

        assign next_ptr[h*ELEM_W +: ELEM_W] = nxt_h[h];
    end

    AST_CURR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_accept |=> (curr_ptr == $past(curr_ptr) + STEP));        // R7
    AST_SEED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        seed_list |=> (curr_ptr == $past(next_ptr)));                // R5
    AST_ARRAY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && mode_q[1]) |=> $stable(next_ptr));              // R11
    AST_SMALL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && mode_q == 2'b00) |=> $stable(next_ptr[PTR_W-1:ELEM_W])); // R9

endmodule

// File: rtl/desc_ptr_seq.sv
module desc_ptr_seq
    import dps_pkg::*;
#(
    parameter int PTR_W   = 32,
    parameter int ELEM_W  = 16,
    parameter int N_SMALL = 4,
    parameter int N_LARGE = 6,
    parameter int N_ARRAY = 4,
    parameter int N_MAX   = (N_SMALL > N_LARGE) ?
                            ((N_SMALL > N_ARRAY) ? N_SMALL : N_ARRAY) :
                            ((N_LARGE > N_ARRAY) ? N_LARGE : N_ARRAY),
    parameter int IDX_W   = (N_MAX > 2) ? $clog2(N_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [1:0]        mode_sel,
    input  logic              start_req,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [PTR_W-1:0]  reg_wdata,
    output logic [PTR_W-1:0]  reg_rdata,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic              mem_rvalid,
    input  logic [ELEM_W-1:0] mem_rdata,
    output logic              elem_valid,
    output logic [ELEM_W-1:0] elem_data,
    output logic [IDX_W-1:0]  elem_idx,
    output logic              desc_done
);

    seq_state_e       state;
    logic [1:0]       mode_q;
    logic             seed_list;
    logic             rsp_accept;
    logic             wr_allow;
    logic [PTR_W-1:0] next_ptr;
    logic [PTR_W-1:0] curr_ptr;

    assign wr_allow = reg_wr && !chan_en && (state == ST_IDLE);

    dps_fsm #(
        .N_SMALL (N_SMALL),
        .N_LARGE (N_LARGE),
        .N_ARRAY (N_ARRAY),
        .IDX_W   (IDX_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .start_req  (start_req),
        .mode_sel   (mode_sel),
        .rsp_valid  (mem_rvalid),
        .state      (state),
        .mode_q     (mode_q),
        .seed_list  (seed_list),
        .mem_req    (mem_req),
        .rsp_accept (rsp_accept),
        .elem_idx   (elem_idx),
        .done_pulse (desc_done)
    );

    dps_ptr_regs #(
        .PTR_W      (PTR_W),
        .ELEM_W     (ELEM_W),
        .IDX_W      (IDX_W),
        .LINK_SMALL (1)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_allow),
        .wr_sel     (reg_sel),
        .wr_data    (reg_wdata),
        .seed_list  (seed_list),
        .rsp_accept (rsp_accept),
        .elem_idx   (elem_idx),
        .elem_data  (mem_rdata),
        .mode_q     (mode_q),
        .fetching   (state == ST_FETCH),
        .next_ptr   (next_ptr),
        .curr_ptr   (curr_ptr)
    );

    assign reg_rdata  = reg_sel ? curr_ptr : next_ptr;
    assign mem_addr   = curr_ptr;
    assign elem_valid = rsp_accept;
    assign elem_data  = mem_rdata;

    AST_LOCK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && chan_en) |=> $stable(next_ptr));          // R3
    AST_LOCK_CURR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && chan_en && !start_req) |=> $stable(curr_ptr)); // R3
    AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rvalid && (state != ST_FETCH)) |-> !elem_valid);            // R6
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |=> !desc_done);                                       // R12

endmodule

// File: tb/desc_ptr_seq_tb.sv
module desc_ptr_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4, NL = 6, NA = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        start_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        elem_valid;
    logic [15:0] elem_data;
    logic [2:0]  elem_idx;
    logic        desc_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [31:0] m_next = '0;
    logic [31:0] m_curr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_ptr_seq #(.N_SMALL(NS), .N_LARGE(NL), .N_ARRAY(NA)) dut_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode_sel(mode_sel),
        .start_req(start_req), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .elem_valid(elem_valid), .elem_data(elem_data), .elem_idx(elem_idx),
        .desc_done(desc_done)
    );

    function automatic logic [15:0] mem_word(input logic [31:0] a);
        return 16'(a[15:0] * 16'd5) ^ a[31:16] ^ 16'h3C6A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic run_desc(input logic [1:0] mode, input int lat_base);
        int n, links, to, lat;
        logic [31:0] seed, addr, v;
        logic [15:0] d;
        n     = mode[1] ? NA : (mode[0] ? NL : NS);
        links = mode[1] ? 0  : (mode[0] ? 2  : 1);
        seed  = mode[1] ? m_curr : m_next;
        @(negedge clk);
        mode_sel = mode; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int k = 0; k < n; k++) begin
            to = 0;
            while (!mem_req && to < 50) begin @(negedge clk); to++; end
            if (to >= 50) begin chk("R6 request missing", 32'd0, 32'd1); return; end
            addr = seed + 32'(2 * k);
            if (k == 0 && !mode[1]) chk("R5 first address", mem_addr, m_next);
            chk("R7 address", mem_addr, addr);
            lat = (lat_base + k) % 3;
            for (int w = 0; w <= lat; w++) begin
                @(negedge clk);
                chk("R6 no second request", {31'd0, mem_req}, 32'd0);
            end
            d = mem_word(addr);
            mem_rvalid = 1'b1; mem_rdata = d;
            #1;
            chk("R8 elem_valid", {31'd0, elem_valid}, 32'd1);
            chk("R8 elem_data", {16'd0, elem_data}, {16'd0, d});
            chk("R8 elem_idx", {29'd0, elem_idx}, 32'(k));
            if (k < links) m_next[16*k +: 16] = d;
            @(negedge clk);
            mem_rvalid = 1'b0;
            chk("R12 done flag", {31'd0, desc_done}, (k == n - 1) ? 32'd1 : 32'd0);
        end
        @(negedge clk);
        chk("R12 done one cycle", {31'd0, desc_done}, 32'd0);
        m_curr = seed + 32'(2 * n);
        rd_reg(1'b1, v);
        chk("R7 current after descriptor", v, m_curr);
        rd_reg(1'b0, v);
        if (mode[1])      chk("R11 next untouched", v, m_next);
        else if (mode[0]) chk("R10 next from link", v, m_next);
        else              chk("R9 next low half from link", v, m_next);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] seeds [3];
        seeds[0] = 32'h0000_1000;
        seeds[1] = 32'h8000_FFFA;
        seeds[2] = 32'hFFFF_FFFC;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
        chk("R1 desc_done in reset", {31'd0, desc_done}, 32'd0);
        chk("R1 elem_valid in reset", {31'd0, elem_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {31'd0, mem_req}, 32'd0);

        // R2: programming while disabled
        wr_reg(1'b0, 32'h1234_5670); m_next = 32'h1234_5670;
        wr_reg(1'b1, 32'hCAFE_0010); m_curr = 32'hCAFE_0010;
        rd_reg(1'b0, v); chk("R2 next readback", v, m_next);
        rd_reg(1'b1, v); chk("R2 current readback", v, m_curr);

        // R4: start ignored while disabled
        @(negedge clk); start_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4 no read while disabled", {31'd0, mem_req}, 32'd0);
        end
        start_req = 1'b0;
        rd_reg(1'b1, v); chk("R4 current not seeded", v, m_curr);

        // R6: stray response while idle
        chan_en = 1'b1;
        @(negedge clk); mem_rvalid = 1'b1; mem_rdata = 16'hBEEF;
        #1 chk("R6 stray response ignored", {31'd0, elem_valid}, 32'd0);
        @(negedge clk); mem_rvalid = 1'b0;
        rd_reg(1'b1, v); chk("R6 current unchanged by stray", v, m_curr);
        rd_reg(1'b0, v); chk("R6 next unchanged by stray", v, m_next);

        // R3: writes dropped while enabled
        wr_reg(1'b0, 32'hDEAD_BEEF);
        wr_reg(1'b1, 32'h0BAD_F00D);
        rd_reg(1'b0, v); chk("R3 next locked", v, m_next);
        rd_reg(1'b1, v); chk("R3 current locked", v, m_curr);
        chan_en = 1'b0;

        // List modes: sweep seeds and latencies, two chained descriptors each
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 3; s++) begin
                wr_reg(1'b0, seeds[s]); m_next = seeds[s];
                chan_en = 1'b1;
                run_desc(2'(md), s);
                run_desc(2'(md), s + 1);
                chan_en = 1'b0;
            end
        end

        // R11: array mode with both encodings, next holds a distinct value
        for (int s = 0; s < 3; s++) begin
            wr_reg(1'b0, 32'h5A5A_0002); m_next = 32'h5A5A_0002;
            wr_reg(1'b1, seeds[s]);      m_curr = seeds[s];
            chan_en = 1'b1;
            run_desc(2'b10, s);
            run_desc(2'b11, s + 2);
            chan_en = 1'b0;
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule